// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset Steering

This block is a watchdog timer set up through a single 8-bit configuration register. The register holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is the multiplier times a power of four chosen by the resolution code. It is counted in sixteenth-second ticks that arrive on a one-cycle tick enable. Software restarts the countdown by writing the register or by reading it back.

When the countdown runs out, the block raises a sticky watchdog flag. The steering bit then picks the action. With the bit set, the block pulses a system reset request, pulses a strobe that tells a neighbouring register to clear one of its bits, and wipes its own configuration to zero. With the bit clear, it pulses an interrupt once. In both cases the countdown then stays idle until the next restart. A zero multiplier disables expiry entirely.

Top module: `wdog_steer`

## Requirements
- R1: After reset, rst_req, irq_pulse, wd_flag and clr_strobe are 0, rdata is 0x00 and no expiry occurs until the register is written or read.
- R2: rdata always shows the stored register. Bit 7 is the steering bit, bits [6:2] are the multiplier M and bits [1:0] are the resolution code S.
- R3: A write stores wdata, clears wd_flag in the next cycle and restarts the countdown from the written value.
- R4: After a restart, expiry happens on exactly the (M × 4^S)-th tick. The outputs change right after that tick's clock edge, and no expiry is visible before it.
- R5: A read strobe restarts the countdown with the value currently stored, without changing that value.
- R6: At expiry wd_flag becomes 1 and stays 1 until the next write.
- R7: At expiry with bit 7 set, rst_req and clr_strobe are each high for exactly one cycle, rdata becomes 0x00, irq_pulse stays 0, and later ticks give no further expiry.
- R8: At expiry with bit 7 clear, irq_pulse is high for exactly one cycle, rst_req and clr_strobe stay 0, the register keeps its value, and later ticks give no second pulse until a restart.
- R9: With M = 0, no expiry ever occurs, whatever S and the steering bit are and however many ticks arrive.
- R10: A write or read in the same cycle as the final tick wins. No expiry occurs, and the countdown restarts in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable, once per sixteenth of a second |
| wr_en | input | 1 | Write strobe for the watchdog register |
| rd_en | input | 1 | Read strobe for the watchdog register (restarts the countdown) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current register value |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| wd_flag | output | 1 | Sticky watchdog-expired flag |
| clr_strobe | output | 1 | One-cycle strobe to clear a bit in a neighbouring register |

## Verification
A wrong tick count shows up as an expiry pulse and a flag rise that come one tick early or late. Every programmed timeout is therefore checked on the tick before expiry and on the expiry tick itself. A countdown left active after expiry gives a second pulse on a later tick, so the bench keeps ticking past each expiry. A register that is not wiped after a reset-steered expiry shows up on rdata in the cycle of the pulse. The bench also forces a restart to collide with the final tick, because a wrong priority there shows up as a spurious pulse one cycle later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Expiry event decoded by the countdown for the register file
   typedef enum logic [1:0] {
      EXP_NONE  = 2'd0,
      EXP_IRQ   = 2'd1,
      EXP_RESET = 2'd2
   } wdog_exp_e;
endpackage

// File: rtl/wdog_span.sv
// Computes multiplier * 4^res as a chain of conditional shift stages.
module wdog_span #(
   parameter int MULT_W = 5,
   parameter int RES_W  = 2,
   parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic [CNT_W-1:0]  span
);
   localparam int MIN_W = MULT_W + 2 * ((1 << RES_W) - 1);

   generate
      if (CNT_W < MIN_W) begin : g_bad_width
         $error("wdog_span: CNT_W too narrow for the largest timeout");
      end
   endgenerate

   logic [CNT_W-1:0] stage [0:RES_W];

   assign stage[0] = CNT_W'(mult);

   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_stage
         // bit i of res contributes a shift of 2 * 2^i
         assign stage[i+1] = res[i] ? (stage[i] << (2 * (1 << i))) : stage[i];
      end
   endgenerate

   assign span = stage[RES_W];
endmodule

// File: rtl/wdog_countdown.sv
// Tick-driven countdown with one-shot expiry and registered action pulses.
module wdog_countdown
   import wdog_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             steer,
   output wdog_exp_e        exp_kind,
   output logic             rst_req,
   output logic             irq_pulse
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wdog_countdown: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             active_q;
   logic             last_tick;

   assign last_tick = active_q && tick_en && !load && (cnt_q == CNT_W'(1));

   always_comb begin
      if (!last_tick)  exp_kind = EXP_NONE;
      else if (steer)  exp_kind = EXP_RESET;
      else             exp_kind = EXP_IRQ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         active_q  <= 1'b0;
         rst_req   <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         rst_req   <= 1'b0;
         irq_pulse <= 1'b0;
         if (load) begin
            cnt_q    <= load_val;
            active_q <= (load_val != '0);
         end else if (active_q && tick_en) begin
            if (cnt_q == CNT_W'(1)) begin
               cnt_q     <= '0;
               active_q  <= 1'b0;
               rst_req   <= steer;
               irq_pulse <= !steer;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   // R9: an armed countdown never holds zero
   a_r9_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q != '0));
   // R7: reset request lasts one cycle
   a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R8: interrupt lasts one cycle
   a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   // R8: the two actions never coincide
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq_pulse));
   // R10: a restart suppresses any action in the following cycle
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !(rst_req || irq_pulse));
endmodule

// File: rtl/wdog_cfg_reg.sv
// Configuration register and sticky flag, updated by writes and expiry.
module wdog_cfg_reg
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  wdog_exp_e         exp_kind,
   output logic [DATA_W-1:0] cfg_q,
   output logic              flag_q,
   output logic              clr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         flag_q <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         if (wr_en) begin
            cfg_q  <= wdata;
            flag_q <= 1'b0;
         end else begin
            case (exp_kind)
               EXP_IRQ: flag_q <= 1'b1;
               EXP_RESET: begin
                  flag_q <= 1'b1;
                  cfg_q  <= '0;
                  clr_q  <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R3: a write leaves the flag clear
   a_r3_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !flag_q);
   // R6: the flag is sticky until a write
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_en) |=> flag_q);
endmodule

// File: rtl/wdog_steer.sv
// Watchdog top: register, timeout span, countdown and steering.
module wdog_steer #(
   parameter int DATA_W = 8,
   parameter int MULT_W = 5,
   parameter int RES_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req,
   output logic              irq_pulse,
   output logic              wd_flag,
   output logic              clr_strobe
);
   import wdog_pkg::*;

   localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);
   localparam int MULT_LSB  = RES_W;
   localparam int STEER_BIT = DATA_W - 1;

   generate
      if (DATA_W != RES_W + MULT_W + 1) begin : g_bad_layout
         $error("wdog_steer: DATA_W must equal RES_W + MULT_W + 1");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_q;
   logic [DATA_W-1:0] src;
   logic [CNT_W-1:0]  span;
   logic              load;
   wdog_exp_e         exp_kind;

   // A write reloads from the new value, a read from the stored one
   assign src  = wr_en ? wdata : cfg_q;
   assign load = wr_en || rd_en;

   wdog_span #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_span (
      .mult (src[MULT_LSB +: MULT_W]),
      .res  (src[RES_W-1:0]),
      .span (span)
   );

   wdog_countdown #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .load      (load),
      .load_val  (span),
      .steer     (cfg_q[STEER_BIT]),
      .exp_kind  (exp_kind),
      .rst_req   (rst_req),
      .irq_pulse (irq_pulse)
   );

   wdog_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wdata    (wdata),
      .exp_kind (exp_kind),
      .cfg_q    (cfg_q),
      .flag_q   (wd_flag),
      .clr_q    (clr_strobe)
   );

   assign rdata = cfg_q;

   // R7: reset action wipes the register, raises the flag and strobes the clear
   a_r7_reset_action: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (rdata == '0 && wd_flag && clr_strobe));
   // R6: an interrupt is always accompanied by the flag
   a_r6_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> wd_flag);
endmodule

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rst_req, irq_pulse, wd_flag, clr_strobe;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   wdog_steer u_wdog_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wdata      (wdata),
      .rdata      (rdata),
      .rst_req    (rst_req),
      .irq_pulse  (irq_pulse),
      .wd_flag    (wd_flag),
      .clr_strobe (clr_strobe)
   );

   // {config value, expected ticks to expiry = M * 4^S}
   localparam int NVEC = 8;
   localparam logic [23:0] VECS [NVEC] = '{
      {8'h04, 16'd1},     // M=1  S=0
      {8'h05, 16'd4},     // M=1  S=1
      {8'h0A, 16'd32},    // M=2  S=2
      {8'h0F, 16'd192},   // M=3  S=3
      {8'h7C, 16'd31},    // M=31 S=0
      {8'h7F, 16'd1984},  // M=31 S=3
      {8'h86, 16'd16},    // steer, M=1  S=2
      {8'hFD, 16'd124}    // steer, M=31 S=1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wdata = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   // Ticks on n consecutive cycles; returns at the negedge after the last one
   task automatic do_ticks(input int n);
      if (n > 0) begin
         @(negedge clk); tick_en = 1'b1;
         repeat (n) @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   // Counts any action pulse seen over n ticks
   task automatic ticks_quiet(input int n, input string req);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         do_ticks(1);
         if (irq_pulse || rst_req || clr_strobe) seen++;
      end
      chk(req, seen, 0);
   endtask

   logic [7:0] vc;
   int         vn;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", rdata, 8'h00);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 irq_pulse", irq_pulse, 0);
      chk("R1 wd_flag", wd_flag, 0);
      chk("R1 clr_strobe", clr_strobe, 0);
      ticks_quiet(20, "R1 idle after reset");

      // Vector walk: R2 R3 R4 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         vc = VECS[i][23:16];
         vn = int'(VECS[i][15:0]);
         do_write(vc);
         chk("R2 readback", rdata, vc);
         chk("R3 flag cleared by write", wd_flag, 0);
         do_ticks(vn - 1);
         chk("R4 no early action", {irq_pulse, rst_req, wd_flag}, 3'b000);
         do_ticks(1);
         chk("R6 flag at expiry", wd_flag, 1);
         if (vc[7]) begin
            chk("R7 rst_req", rst_req, 1);
            chk("R7 clr_strobe", clr_strobe, 1);
            chk("R7 no irq", irq_pulse, 0);
            chk("R7 register wiped", rdata, 8'h00);
            @(negedge clk);
            chk("R7 pulses one cycle", {rst_req, clr_strobe}, 2'b00);
            ticks_quiet(5, "R7 idle after reset action");
         end else begin
            chk("R8 irq_pulse", irq_pulse, 1);
            chk("R8 no reset", {rst_req, clr_strobe}, 2'b00);
            chk("R8 register kept", rdata, vc);
            @(negedge clk);
            chk("R8 pulse one cycle", irq_pulse, 0);
            ticks_quiet(5, "R8 no second pulse");
         end
         chk("R6 flag sticky", wd_flag, 1);
      end

      // R9: zero multiplier never expires
      do_write(8'h03);
      ticks_quiet(300, "R9 M=0 S=3");
      chk("R9 flag stays clear", wd_flag, 0);
      do_write(8'h80);
      ticks_quiet(20, "R9 M=0 steer");
      chk("R9 flag stays clear steer", wd_flag, 0);

      // R5: a read restarts the countdown (M=3 S=0 -> 3 ticks)
      do_write(8'h0C);
      do_ticks(2);
      do_read();
      chk("R5 read keeps value", rdata, 8'h0C);
      do_ticks(2);
      chk("R5 no expiry after restart", {irq_pulse, wd_flag}, 2'b00);
      do_ticks(1);
      chk("R5 expiry 3 ticks after read", irq_pulse, 1);

      // R10: write collides with final tick (M=2 S=0 -> 2 ticks)
      do_write(8'h08);
      do_ticks(1);
      @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wdata = 8'h08;
      @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
      chk("R10 write beats last tick", {irq_pulse, wd_flag}, 2'b00);
      do_ticks(1);
      chk("R10 restart full after write", irq_pulse, 0);
      do_ticks(1);
      chk("R10 expiry after write restart", irq_pulse, 1);

      // R10: read collides with final tick
      do_write(8'h08);
      do_ticks(1);
      @(negedge clk); tick_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
      chk("R10 read beats last tick", {irq_pulse, wd_flag}, 2'b00);
      do_ticks(1);
      chk("R10 restart full after read", irq_pulse, 0);
      do_ticks(1);
      chk("R10 expiry after read restart", irq_pulse, 1);

      // R7: after a reset action a read reloads zero and stays idle
      do_write(8'h84);
      do_ticks(1);
      chk("R7 short steer expiry", rst_req, 1);
      do_read();
      ticks_quiet(10, "R7 read after wipe stays idle");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog timeout in bench");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule